// File: doc/BRIEF.md
# Byte-Wide Boot Image Loader

This block runs once after reset and fills a 24-bit-wide internal program RAM from a byte-wide external boot memory. On the first clock after reset it samples two strap pins and a 3-bit page number. When both straps are low it performs a memory boot. It pulls the memory select low and issues timed read pulses. It assembles the fetched bytes into instructions and writes each instruction into the program RAM. When both straps are not low it leaves the memory untouched and releases the core at once.

The external memory is organised in 4-byte slots. The first byte of each slot is padding and the other three hold one instruction, most significant byte first. The padding byte of slot 0 instead holds a length code N: the loader copies (N+1)*8 instructions and skips every padding byte. After the last program RAM write it raises a done flag together with the core-run signal. Both stay high until the next reset.

Top module: `eprom_boot_seq`

## Requirements
- R1: Straps are sampled on the first rising clock edge after reset release and only then. A memory boot runs only if both `strap0_i` and `strap1_i` are 0. For any other combination `ext_boot_sel_n_o` and `ext_rd_n_o` stay high, `pm_we_o` stays low, `boot_done_o` stays low and `core_run_o` goes high.
- R2: While reset is asserted, `ext_boot_sel_n_o`=1, `ext_rd_n_o`=1, `pm_we_o`=0, `boot_done_o`=0 and `core_run_o`=0.
- R3: `ext_boot_sel_n_o` (active low) is low during every read pulse of a memory boot and is high once `boot_done_o` is high.
- R4: Each read holds `ext_rd_n_o` low for exactly WAIT_CYC consecutive cycles, default 3. It is followed by at least one high cycle. The data byte is taken from `ext_data_i` in the last low cycle.
- R5: `ext_addr_o` is stable while `ext_rd_n_o` is low. Its bits [15:13] equal the page sampled at reset, and later changes of `page_i` have no effect.
- R6: The first read of a boot uses offset 0 (`ext_addr_o[12:0]`=0). That byte is the length code N, and the boot loads (N+1)*8 instructions.
- R7: Instruction w is fetched from offsets 4w+1, 4w+2 and 4w+3, in that order. No offset 4w with w>0 is ever read.
- R8: The byte at 4w+1 lands in `pm_wdata_o[23:16]`, the byte at 4w+2 in [15:8] and the byte at 4w+3 in [7:0].
- R9: Each instruction gets exactly one `pm_we_o` pulse. `pm_addr_o` runs 0,1,2,... with no gaps or repeats.
- R10: `boot_done_o` and `core_run_o` rise together one cycle after the last program RAM write. They stay high until reset, and no further reads or writes occur after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strap0_i | input | 1 | Boot strap pin 0 |
| strap1_i | input | 1 | Boot strap pin 1 |
| page_i | input | 3 | Boot page number, sampled with the straps |
| ext_addr_o | output | 16 | External byte address {page, offset} |
| ext_boot_sel_n_o | output | 1 | Active-low boot memory select |
| ext_rd_n_o | output | 1 | Active-low read strobe |
| ext_data_i | input | 8 | Byte returned by the external memory |
| pm_we_o | output | 1 | Program RAM write enable |
| pm_addr_o | output | 11 | Program RAM word address |
| pm_wdata_o | output | 24 | Program RAM write data |
| boot_done_o | output | 1 | Memory boot finished |
| core_run_o | output | 1 | Core released |

## Verification
The bench's memory model drives valid data only in the final low cycle of each read and drives junk in every other cycle. A loader that captures early therefore writes wrong instructions. The padding bytes hold nonzero junk, so a loader that fetches them, or that shifts lanes, shows up as a wrong offset sequence or wrong data. The bench covers the length codes 0 and 255 (a full 2048-word image), a nonzero page, and strap and page inputs that change mid-boot. It also runs every non-boot strap combination. An off-by-one in the length scaling or the stop test shows up as a wrong write count or a late done. Resampling of the straps shows up as an aborted boot.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

   typedef enum logic [2:0] {
      ST_SAMPLE,
      ST_LEN,
      ST_WORDS,
      ST_FLUSH,
      ST_DONE,
      ST_SKIP
   } boot_state_t;

   typedef enum logic [1:0] {
      RD_IDLE,
      RD_LOW,
      RD_GAP
   } rd_state_t;

endpackage

// File: rtl/bs_ext_reader.sv
module bs_ext_reader
   import boot_seq_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int BYTE_W   = 8,
   parameter int WAIT_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              rdy_o,
   output logic              vld_o,
   output logic [BYTE_W-1:0] byte_o,
   output logic [ADDR_W-1:0] ext_addr_o,
   output logic              ext_rd_n_o,
   input  logic [BYTE_W-1:0] ext_data_i
);

   if (WAIT_CYC < 1) begin : g_bad_wait
      $error("bs_ext_reader: WAIT_CYC must be at least 1");
   end

   rd_state_t st_q;
   logic      last_low;

   if (WAIT_CYC == 1) begin : g_single
      assign last_low = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(WAIT_CYC);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            cnt_q <= '0;
         end else if (st_q == RD_LOW) begin
            cnt_q <= last_low ? '0 : cnt_q + 1'b1;
         end
      end
      assign last_low = (cnt_q == CW'(WAIT_CYC - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q       <= RD_IDLE;
         ext_rd_n_o <= 1'b1;
         ext_addr_o <= '0;
         vld_o      <= 1'b0;
         byte_o     <= '0;
      end else begin
         vld_o <= 1'b0;
         unique case (st_q)
            RD_IDLE: begin
               if (req_i) begin
                  ext_addr_o <= addr_i;
                  ext_rd_n_o <= 1'b0;
                  st_q       <= RD_LOW;
               end
            end
            RD_LOW: begin
               if (last_low) begin
                  byte_o     <= ext_data_i;
                  vld_o      <= 1'b1;
                  ext_rd_n_o <= 1'b1;
                  st_q       <= RD_GAP;
               end
            end
            RD_GAP: st_q <= RD_IDLE;
            default: st_q <= RD_IDLE;
         endcase
      end
   end

   assign rdy_o = (st_q == RD_IDLE);

endmodule

// File: rtl/bs_word_packer.sv
module bs_word_packer #(
   parameter int WORD_W    = 24,
   parameter int BYTE_W    = 8,
   parameter int PM_ADDR_W = 11,
   localparam int LANES    = WORD_W / BYTE_W,
   localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 vld_i,
   input  logic [BYTE_W-1:0]    byte_i,
   input  logic [LANE_W-1:0]    lane_i,
   input  logic [PM_ADDR_W-1:0] word_idx_i,
   output logic                 pm_we_o,
   output logic [PM_ADDR_W-1:0] pm_addr_o,
   output logic [WORD_W-1:0]    pm_wdata_o
);

   if (WORD_W % BYTE_W != 0) begin : g_bad_width
      $error("bs_word_packer: WORD_W must be a multiple of BYTE_W");
   end

   logic [WORD_W-1:0] acc_q;
   logic [WORD_W-1:0] word_next;
   logic              last_lane;

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      localparam int HI = WORD_W - 1 - k * BYTE_W;
      assign word_next[HI -: BYTE_W] =
         (lane_i == LANE_W'(k)) ? byte_i : acc_q[HI -: BYTE_W];
   end

   assign last_lane = (lane_i == LANE_W'(LANES - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q      <= '0;
         pm_we_o    <= 1'b0;
         pm_addr_o  <= '0;
         pm_wdata_o <= '0;
      end else begin
         pm_we_o <= 1'b0;
         if (vld_i) begin
            acc_q <= word_next;
            if (last_lane) begin
               pm_we_o    <= 1'b1;
               pm_addr_o  <= word_idx_i;
               pm_wdata_o <= word_next;
            end
         end
      end
   end

endmodule

// File: rtl/bs_boot_ctrl.sv
module bs_boot_ctrl
   import boot_seq_pkg::*;
#(
   parameter int PAGE_W    = 3,
   parameter int OFF_W     = 13,
   parameter int BYTE_W    = 8,
   parameter int PM_ADDR_W = 11,
   parameter int LANES     = 3,
   parameter int LEN_UNIT  = 8,
   localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1,
   localparam int SLOT_SH  = $clog2(LANES + 1),
   localparam int CNT_W    = PM_ADDR_W + 1,
   localparam int ADDR_W   = PAGE_W + OFF_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 strap0_i,
   input  logic                 strap1_i,
   input  logic [PAGE_W-1:0]    page_i,
   input  logic                 rd_rdy_i,
   input  logic                 rd_vld_i,
   input  logic [BYTE_W-1:0]    rd_byte_i,
   output logic                 rd_req_o,
   output logic [ADDR_W-1:0]    rd_addr_o,
   output logic                 pk_vld_o,
   output logic [LANE_W-1:0]    lane_o,
   output logic [PM_ADDR_W-1:0] word_idx_o,
   output logic                 sel_n_o,
   output logic                 done_o,
   output logic                 run_o
);

   if ((1 << SLOT_SH) != LANES + 1) begin : g_bad_slot
      $error("bs_boot_ctrl: slot of LANES+1 bytes must be a power of two");
   end
   if (OFF_W != PM_ADDR_W + SLOT_SH) begin : g_bad_off
      $error("bs_boot_ctrl: OFF_W must cover the whole program RAM in slots");
   end
   if ((1 << BYTE_W) * LEN_UNIT > (1 << PM_ADDR_W)) begin : g_bad_len
      $error("bs_boot_ctrl: largest length code exceeds program RAM");
   end

   boot_state_t          st_q;
   logic [PAGE_W-1:0]    page_q;
   logic                 pend_q;
   logic [LANE_W-1:0]    lane_q;
   logic [CNT_W-1:0]     word_q;
   logic [CNT_W-1:0]     total_q;
   logic [CNT_W-1:0]     total_next;
   logic [CNT_W-1:0]     word_inc;
   logic [OFF_W-1:0]     off;
   logic                 fetching;

   assign fetching   = (st_q == ST_LEN) || (st_q == ST_WORDS);
   assign total_next = (CNT_W'(rd_byte_i) + CNT_W'(1)) * CNT_W'(LEN_UNIT);
   assign word_inc   = word_q + CNT_W'(1);

   always_comb begin
      if (st_q == ST_WORDS) begin
         off = {word_q[PM_ADDR_W-1:0], {SLOT_SH{1'b0}}}
             | OFF_W'({1'b0, lane_q} + {{LANE_W{1'b0}}, 1'b1});
      end else begin
         off = '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_SAMPLE;
         page_q  <= '0;
         pend_q  <= 1'b0;
         lane_q  <= '0;
         word_q  <= '0;
         total_q <= '0;
      end else begin
         if (rd_req_o) begin
            pend_q <= 1'b1;
         end else if (rd_vld_i) begin
            pend_q <= 1'b0;
         end
         unique case (st_q)
            ST_SAMPLE: begin
               page_q <= page_i;
               st_q   <= (!strap0_i && !strap1_i) ? ST_LEN : ST_SKIP;
            end
            ST_LEN: begin
               if (rd_vld_i) begin
                  total_q <= total_next;
                  word_q  <= '0;
                  lane_q  <= '0;
                  st_q    <= ST_WORDS;
               end
            end
            ST_WORDS: begin
               if (rd_vld_i) begin
                  if (lane_q == LANE_W'(LANES - 1)) begin
                     lane_q <= '0;
                     word_q <= word_inc;
                     if (word_inc == total_q) begin
                        st_q <= ST_FLUSH;
                     end
                  end else begin
                     lane_q <= lane_q + 1'b1;
                  end
               end
            end
            ST_FLUSH: st_q <= ST_DONE;
            ST_DONE:  st_q <= ST_DONE;
            ST_SKIP:  st_q <= ST_SKIP;
            default:  st_q <= ST_SKIP;
         endcase
      end
   end

   assign rd_req_o   = fetching && rd_rdy_i && !pend_q;
   assign rd_addr_o  = {page_q, off};
   assign pk_vld_o   = rd_vld_i && (st_q == ST_WORDS);
   assign lane_o     = lane_q;
   assign word_idx_o = word_q[PM_ADDR_W-1:0];
   assign sel_n_o    = !fetching;
   assign done_o     = (st_q == ST_DONE);
   assign run_o      = (st_q == ST_DONE) || (st_q == ST_SKIP);

endmodule

// File: rtl/eprom_boot_seq.sv
module eprom_boot_seq #(
   parameter int PAGE_W    = 3,
   parameter int OFF_W     = 13,
   parameter int BYTE_W    = 8,
   parameter int WORD_W    = 24,
   parameter int PM_ADDR_W = 11,
   parameter int WAIT_CYC  = 3,
   parameter int LEN_UNIT  = 8,
   localparam int ADDR_W   = PAGE_W + OFF_W,
   localparam int LANES    = WORD_W / BYTE_W,
   localparam int LANE_W   = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 strap0_i,
   input  logic                 strap1_i,
   input  logic [PAGE_W-1:0]    page_i,
   output logic [ADDR_W-1:0]    ext_addr_o,
   output logic                 ext_boot_sel_n_o,
   output logic                 ext_rd_n_o,
   input  logic [BYTE_W-1:0]    ext_data_i,
   output logic                 pm_we_o,
   output logic [PM_ADDR_W-1:0] pm_addr_o,
   output logic [WORD_W-1:0]    pm_wdata_o,
   output logic                 boot_done_o,
   output logic                 core_run_o
);

   if (LANES < 2) begin : g_bad_lanes
      $error("eprom_boot_seq: WORD_W must hold at least two bytes");
   end

   logic                 rd_req;
   logic [ADDR_W-1:0]    rd_addr;
   logic                 rd_rdy;
   logic                 rd_vld;
   logic [BYTE_W-1:0]    rd_byte;
   logic                 pk_vld;
   logic [LANE_W-1:0]    lane;
   logic [PM_ADDR_W-1:0] word_idx;

   bs_boot_ctrl #(
      .PAGE_W   (PAGE_W),
      .OFF_W    (OFF_W),
      .BYTE_W   (BYTE_W),
      .PM_ADDR_W(PM_ADDR_W),
      .LANES    (LANES),
      .LEN_UNIT (LEN_UNIT)
   ) ctrl_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .strap0_i  (strap0_i),
      .strap1_i  (strap1_i),
      .page_i    (page_i),
      .rd_rdy_i  (rd_rdy),
      .rd_vld_i  (rd_vld),
      .rd_byte_i (rd_byte),
      .rd_req_o  (rd_req),
      .rd_addr_o (rd_addr),
      .pk_vld_o  (pk_vld),
      .lane_o    (lane),
      .word_idx_o(word_idx),
      .sel_n_o   (ext_boot_sel_n_o),
      .done_o    (boot_done_o),
      .run_o     (core_run_o)
   );

   bs_ext_reader #(
      .ADDR_W  (ADDR_W),
      .BYTE_W  (BYTE_W),
      .WAIT_CYC(WAIT_CYC)
   ) rdr_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_i     (rd_req),
      .addr_i    (rd_addr),
      .rdy_o     (rd_rdy),
      .vld_o     (rd_vld),
      .byte_o    (rd_byte),
      .ext_addr_o(ext_addr_o),
      .ext_rd_n_o(ext_rd_n_o),
      .ext_data_i(ext_data_i)
   );

   bs_word_packer #(
      .WORD_W   (WORD_W),
      .BYTE_W   (BYTE_W),
      .PM_ADDR_W(PM_ADDR_W)
   ) pack_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .vld_i     (pk_vld),
      .byte_i    (rd_byte),
      .lane_i    (lane),
      .word_idx_i(word_idx),
      .pm_we_o   (pm_we_o),
      .pm_addr_o (pm_addr_o),
      .pm_wdata_o(pm_wdata_o)
   );

endmodule

// File: rtl/eprom_boot_seq_chk.sv
module eprom_boot_seq_chk #(
   parameter int ADDR_W    = 16,
   parameter int PM_ADDR_W = 11,
   parameter int WAIT_CYC  = 3
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 strap0_i,
   input logic                 strap1_i,
   input logic [ADDR_W-1:0]    ext_addr_o,
   input logic                 ext_boot_sel_n_o,
   input logic                 ext_rd_n_o,
   input logic                 pm_we_o,
   input logic [PM_ADDR_W-1:0] pm_addr_o,
   input logic                 boot_done_o,
   input logic                 core_run_o
);

   logic [15:0]          low_cnt;
   logic                 armed_q;
   logic                 skip_q;
   logic [PM_ADDR_W-1:0] wr_exp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         low_cnt <= '0;
         armed_q <= 1'b1;
         skip_q  <= 1'b0;
         wr_exp  <= '0;
      end else begin
         low_cnt <= ext_rd_n_o ? '0 : low_cnt + 16'd1;
         if (armed_q) begin
            armed_q <= 1'b0;
            skip_q  <= strap0_i || strap1_i;
         end
         if (pm_we_o) begin
            wr_exp <= wr_exp + 1'b1;
         end
      end
   end

   // R4
   rd_pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_rd_n_o) |-> (low_cnt == 16'(WAIT_CYC)));

   // R4
   rd_low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_rd_n_o |-> (low_cnt < 16'(WAIT_CYC)));

   // R4
   rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ext_rd_n_o) |=> ext_rd_n_o);

   // R3
   sel_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ext_rd_n_o |-> !ext_boot_sel_n_o);

   // R5
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_rd_n_o && !$fell(ext_rd_n_o)) |-> $stable(ext_addr_o));

   // R1
   skip_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      skip_q |-> (ext_rd_n_o && ext_boot_sel_n_o && !pm_we_o
                  && core_run_o && !boot_done_o));

   // R9
   pm_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pm_we_o |-> (pm_addr_o == wr_exp));

   // R10
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done_o |=> (boot_done_o && core_run_o));

   // R10
   done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      boot_done_o |-> (ext_rd_n_o && ext_boot_sel_n_o && !pm_we_o));

   // R10
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boot_done_o) |-> $past(pm_we_o));

endmodule

bind eprom_boot_seq eprom_boot_seq_chk #(
   .ADDR_W   (PAGE_W + OFF_W),
   .PM_ADDR_W(PM_ADDR_W),
   .WAIT_CYC (WAIT_CYC)
) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .strap0_i        (strap0_i),
   .strap1_i        (strap1_i),
   .ext_addr_o      (ext_addr_o),
   .ext_boot_sel_n_o(ext_boot_sel_n_o),
   .ext_rd_n_o      (ext_rd_n_o),
   .pm_we_o         (pm_we_o),
   .pm_addr_o       (pm_addr_o),
   .boot_done_o     (boot_done_o),
   .core_run_o      (core_run_o)
);

// File: tb/eprom_boot_seq_tb_top.sv
module eprom_boot_seq_tb_top;

   localparam int WAIT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s0 = 1'b0;
   logic        s1 = 1'b0;
   logic [2:0]  pg = 3'd0;
   logic [15:0] ext_addr;
   logic        sel_n;
   logic        rd_n;
   logic [7:0]  ext_data = 8'h00;
   logic        pm_we;
   logic [10:0] pm_addr;
   logic [23:0] pm_wdata;
   logic        done;
   logic        run;

   always #10 clk = ~clk;

   eprom_boot_seq #(.WAIT_CYC(WAIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .strap0_i(s0), .strap1_i(s1), .page_i(pg),
      .ext_addr_o(ext_addr), .ext_boot_sel_n_o(sel_n), .ext_rd_n_o(rd_n),
      .ext_data_i(ext_data), .pm_we_o(pm_we), .pm_addr_o(pm_addr),
      .pm_wdata_o(pm_wdata), .boot_done_o(done), .core_run_o(run)
   );

   int tests = 0;
   int fails = 0;
   int cyc = 0;
   bit finished = 0;

   logic [7:0]  len_cur = 8'd0;
   logic [15:0] salt_cur = 16'd0;
   logic [2:0]  pg_cur = 3'd0;

   int clr_req = 0;
   int clr_seen = 0;
   int n_rd, n_wr, lowcnt, bad_len, bad_sel, bad_stab, bad_page, bad_order;
   int bad_data, bad_waddr, sel_low_cnt, last_wr, rise_cyc;
   logic [15:0] a_start;
   logic [23:0] d_act, d_exp;
   logic        done_prev;

   function automatic logic [7:0] mem_byte(input logic [15:0] a);
      logic [15:0] t;
      if (a[12:0] == 13'd0) return len_cur;
      t = (a * 16'd40503) ^ salt_cur;
      return t[15:8] ^ t[7:0] ^ a[7:0];
   endfunction

   function automatic logic [12:0] exp_off(input int k);
      if (k == 0) return 13'd0;
      return 13'(4 * ((k - 1) / 3) + 1 + (k - 1) % 3);
   endfunction

   function automatic logic [23:0] exp_word(input logic [10:0] w);
      return {mem_byte({pg_cur, w, 2'b01}), mem_byte({pg_cur, w, 2'b10}),
              mem_byte({pg_cur, w, 2'b11})};
   endfunction

   // memory model and monitor, sampled at the falling edge
   always @(negedge clk) begin
      cyc++;
      if (clr_seen != clr_req) begin
         clr_seen = clr_req;
         n_rd = 0; n_wr = 0; lowcnt = 0; bad_len = 0; bad_sel = 0;
         bad_stab = 0; bad_page = 0; bad_order = 0; bad_data = 0;
         bad_waddr = 0; sel_low_cnt = 0; last_wr = -1; rise_cyc = -1;
         done_prev = 1'b0;
      end
      if (rst_n) begin
         if (!sel_n) sel_low_cnt++;
         if (!rd_n) begin
            lowcnt++;
            if (lowcnt == 1) begin
               if (ext_addr[12:0] != exp_off(n_rd)) bad_order++;
               if (ext_addr[15:13] != pg_cur) bad_page++;
               a_start = ext_addr;
               n_rd++;
            end else if (ext_addr != a_start) bad_stab++;
            if (sel_n) bad_sel++;
            if (lowcnt > WAIT) bad_len++;
         end else begin
            if (lowcnt != 0 && lowcnt != WAIT) bad_len++;
            lowcnt = 0;
         end
         if (pm_we) begin
            if (pm_addr != 11'(n_wr)) bad_waddr++;
            if (pm_wdata != exp_word(pm_addr)) begin
               if (bad_data == 0) begin
                  d_act = pm_wdata;
                  d_exp = exp_word(pm_addr);
               end
               bad_data++;
            end
            n_wr++;
            last_wr = cyc;
         end
         if (done && !done_prev) rise_cyc = cyc;
         done_prev = done;
      end
      ext_data = (!rd_n && lowcnt == WAIT) ? mem_byte(ext_addr)
                                           : (8'hC3 ^ 8'(cyc));
      if (cyc > 190000 && !finished) begin
         finished = 1;
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected below 190000", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic run_boot(input bit a, input bit b, input logic [2:0] page,
                           input logic [7:0] n, input logic [15:0] salt);
      bit load;
      int words;
      int limit;
      int rd_at_done;
      load  = !a && !b;
      words = (int'(n) + 1) * 8;
      rst_n = 1'b0;
      s0 = a; s1 = b; pg = page;
      pg_cur = page; len_cur = n; salt_cur = salt;
      repeat (3) @(negedge clk);
      // R2 reset state
      check(sel_n == 1'b1 && rd_n == 1'b1 && pm_we == 1'b0, "R2",
            "strobes/write during reset", {sel_n, rd_n, pm_we}, 3'b110);
      check(done == 1'b0 && run == 1'b0, "R2", "done/run during reset",
            {done, run}, 0);
      clr_req++;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      s0 = 1'b1; s1 = 1'b1; pg = ~page;   // late changes must be ignored
      if (load) begin
         limit = (words * 3 + 1) * (WAIT + 3) + 50;
         for (int i = 0; i < limit && !done; i++) @(negedge clk);
         rd_at_done = n_rd;
         repeat (12) @(negedge clk);
         check(done && run, "R10", "done and run high", {done, run}, 3);
         check(rise_cyc == last_wr + 1, "R10", "done rise after last write",
               rise_cyc, last_wr + 1);
         check(n_rd == rd_at_done && sel_n, "R10", "quiet after done",
               n_rd, rd_at_done);
         check(n_wr == words, "R9", "write count", n_wr, words);
         check(bad_waddr == 0, "R9", "write address order", bad_waddr, 0);
         check(n_rd == 1 + 3 * words, "R6", "read count", n_rd, 1 + 3 * words);
         check(bad_order == 0, "R7", "offset sequence errors", bad_order, 0);
         check(bad_data == 0, "R8", "instruction data", d_act, d_exp);
         check(bad_len == 0, "R4", "strobe pulse length errors", bad_len, 0);
         check(bad_stab == 0 && bad_page == 0, "R5", "address hold/page",
               bad_stab + bad_page, 0);
         check(bad_sel == 0, "R3", "select low during reads", bad_sel, 0);
      end else begin
         repeat (60) @(negedge clk);
         check(n_rd == 0 && n_wr == 0, "R1", "no access on skip",
               n_rd + n_wr, 0);
         check(sel_low_cnt == 0, "R1", "select stays high on skip",
               sel_low_cnt, 0);
         check(run && !done, "R1", "run high done low on skip",
               {run, done}, 2);
      end
   endtask

   initial begin
      int r;
      r = $urandom(32'h5EED_0B07);
      // directed corners
      run_boot(1'b0, 1'b0, 3'd0, 8'd0,   16'h1234);
      run_boot(1'b0, 1'b0, 3'd5, 8'd2,   16'hBEEF);
      run_boot(1'b0, 1'b1, 3'd0, 8'd3,   16'h0000);
      run_boot(1'b1, 1'b0, 3'd2, 8'd3,   16'h0000);
      run_boot(1'b1, 1'b1, 3'd7, 8'd3,   16'h0000);
      run_boot(1'b0, 1'b0, 3'd7, 8'd255, 16'h7A51);
      // constrained random runs
      for (int i = 0; i < 6; i++) begin
         logic [1:0] st;
         st = ($urandom % 3 == 0) ? 2'($urandom) : 2'b00;
         run_boot(st[0], st[1], 3'($urandom), 8'($urandom % 12),
                  16'($urandom));
      end
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule